// File: doc/BRIEF.md
# Line-Boundary Access Splitter for a 64-bit AXI Read/Write Address Channel

This block sits between a load/store unit and the address channels of a 64-bit AXI master port. It accepts one memory request at a time: a byte address, a direction, and a count. The count is either a plain byte count or, in word mode, a number of 32-bit words as used by multiple-register loads. From this it produces one or two address-channel transactions, each with address, burst type, size, length and, for writes, one byte-strobe vector per beat.

Memory is organised in 32-byte lines. An access that stays inside one line becomes a single incrementing burst. An access that runs past the end of its line is cut at the boundary into a head piece, on the lower line, and a tail piece, starting at the base of the next line. Partial pieces that fit in one bus beat get narrow transfer sizes. The head uses the smallest aligned power-of-two window that covers its bytes. The tail uses the request's own size. The request side is held off while the transactions drain. The second transaction is offered only after the first has been taken.

Top module: `axs_split`

## Requirements
- R1: `req_ready` is 1 only while no transaction is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Requests presented while `req_ready` is 0 are ignored and do not alter the transactions in flight.
- R2: The access length is `req_count` bytes when `req_wordmode` is 0, and `req_count`×4 bytes when it is 1; the length must be 1 to 32. An access whose bytes stay in one 32-byte line yields exactly one transaction. An access that spans two lines yields exactly two transactions: first on the lower line, then one whose address has offset 0 in the next line (address wraps modulo 2^AW). No transaction covers bytes outside its own line.
- R3: Every transaction has `ax_burst` = 2'b01 (incrementing). `ax_len` is the beat count minus one.
- R4: A piece whose bytes touch more than one 8-byte beat slot uses `ax_size` = 3 (8 bytes). Its address is the piece start rounded down to 8 bytes. `ax_len` is the last slot index minus the first.
- R5: A single-slot piece that is the only piece or the head piece uses the smallest `ax_size` (log2 of bytes: 0=1, 1=2, 2=4, 3=8) whose aligned window covers all its bytes. Its address is the piece start rounded down to that size.
- R6: A single-slot tail piece uses the request length rounded up to a power of two, capped at 8 bytes, as its size. Its address is the next line base.
- R7: `ax_strb` bit 8·b+j is the strobe of byte lane j in beat b of the transaction. For writes it is 1 exactly for lanes holding bytes of the piece. For reads all strobe bits are 0.
- R8: While `ax_valid` is 1 and `ax_ready` is 0, `ax_valid` stays 1 and address, size, length and strobes hold steady. The tail transaction appears only after the head has been accepted.
- R9: After reset `req_ready` is 1 and `ax_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Byte address of first byte |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wordmode | input | 1 | 1 = count is in 32-bit words |
| req_count | input | CW | Byte or word count |
| ax_valid | output | 1 | Address transaction offered |
| ax_ready | input | 1 | Address transaction taken |
| ax_write | output | 1 | Direction of the transaction |
| ax_addr | output | AW | Transaction address |
| ax_burst | output | 2 | Burst type, always incrementing |
| ax_size | output | 3 | log2 of bytes per beat |
| ax_len | output | LENW | Beats minus one |
| ax_strb | output | 32 | Per-beat byte strobes, 8 bits per beat, beat 0 lowest |

## Verification
The main function is driven with the multi-word load that spans lines, 32-bit loads at line offsets 29 and 31, and a halfword store at offset 31. These cases separate the head rule (smallest covering window) from the tail rule (request size at the line base). In-line stores at unaligned, aligned-full-line and single-byte positions show multi-beat bursts against narrow single beats and check lane placement in the per-beat strobes. A word-mode store with an 8-byte head, a 3-byte split store, and a load that wraps the top of the address space cover the remaining corners. A stalled `ax_ready`, together with a request offered while busy, shows that transactions hold and that nothing extra is issued.

// File: rtl/axs_pkg.sv
`timescale 1ns/1ps
package axs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_TAIL = 2'd2
  } axs_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;

  // smallest k (<= cap) with 2**k >= n
  function automatic int ceil_lg_cap(input int n, input int cap);
    int res;
    res = cap;
    for (int i = 7; i >= 0; i--) begin
      if (i <= cap && (1 << i) >= n) res = i;
    end
    return res;
  endfunction

  // smallest k (<= cap) whose aligned 2**k window holds both s and l
  function automatic int cover_lg(input int s, input int l, input int cap);
    int res;
    res = cap;
    for (int i = 7; i >= 0; i--) begin
      if (i <= cap && (s >> i) == (l >> i)) res = i;
    end
    return res;
  endfunction

  // access length in bytes from count and mode
  function automatic int access_bytes(input int cnt, input logic wordmode);
    return wordmode ? cnt * 4 : cnt;
  endfunction

endpackage

// File: rtl/axs_seq.sv
`timescale 1ns/1ps
module axs_seq #(
  parameter int AW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_wordmode,
  input  logic [CW-1:0] req_count,
  input  logic          ax_ready,
  input  logic          split,
  output logic          ax_valid,
  output logic          in_tail,
  output logic          ev_accept,
  output logic          ev_issue,
  output logic [AW-1:0] lat_addr,
  output logic          lat_write,
  output logic          lat_wordmode,
  output logic [CW-1:0] lat_count
);
  import axs_pkg::*;

  axs_state_e state_q, state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign ax_valid  = (state_q != ST_IDLE);
  assign in_tail   = (state_q == ST_TAIL);
  assign ev_accept = req_valid && req_ready;
  assign ev_issue  = ax_valid && ax_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ev_accept) state_d = ST_HEAD;
      ST_HEAD: if (ev_issue)  state_d = split ? ST_TAIL : ST_IDLE;
      ST_TAIL: if (ev_issue)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      lat_addr     <= '0;
      lat_write    <= 1'b0;
      lat_wordmode <= 1'b0;
      lat_count    <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        lat_addr     <= req_addr;
        lat_write    <= req_write;
        lat_wordmode <= req_wordmode;
        lat_count    <= req_count;
      end
    end
  end

endmodule

// File: rtl/axs_plan.sv
`timescale 1ns/1ps
module axs_plan #(
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int CW         = 6,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int BOFF      = $clog2(BUS_BYTES)
) (
  input  logic [OFFW-1:0] off,
  input  logic [CW-1:0]   count,
  input  logic            wordmode,
  output logic            split,
  output logic [OFFW:0]   head_n,
  output logic [OFFW:0]   tail_n,
  output logic [2:0]      nat_lg
);
  import axs_pkg::*;

  int total;
  int endp;

  always_comb begin
    total  = access_bytes(int'(count), wordmode);
    endp   = int'(off) + total;
    split  = (endp > LINE_BYTES);
    head_n = split ? (OFFW+1)'(LINE_BYTES - int'(off)) : (OFFW+1)'(total);
    tail_n = split ? (OFFW+1)'(endp - LINE_BYTES) : '0;
    nat_lg = 3'(ceil_lg_cap(total, BOFF));
  end

endmodule

// File: rtl/axs_piece.sv
`timescale 1ns/1ps
module axs_piece #(
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LENW       = 8,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int BOFF      = $clog2(BUS_BYTES),
  localparam int NBEAT     = LINE_BYTES / BUS_BYTES,
  localparam int SW        = NBEAT * BUS_BYTES
) (
  input  logic [OFFW-1:0] start_off,
  input  logic [OFFW:0]   nbytes,
  input  logic            is_tail,
  input  logic [2:0]      nat_lg,
  input  logic            wr,
  output logic [2:0]      sz,
  output logic [OFFW-1:0] aoff,
  output logic [LENW-1:0] len,
  output logic [SW-1:0]   strb
);
  import axs_pkg::*;

  int s, l, fb, lb, k;

  always_comb begin
    s  = int'(start_off);
    l  = s + int'(nbytes) - 1;
    fb = s / BUS_BYTES;
    lb = l / BUS_BYTES;
    if (fb != lb) begin
      k   = BOFF;
      len = LENW'(lb - fb);
    end else begin
      k   = is_tail ? int'(nat_lg) : cover_lg(s, l, BOFF);
      len = '0;
    end
    sz   = 3'(k);
    aoff = OFFW'((s >> k) << k);
  end

  // per-beat, per-lane byte enables
  for (genvar b = 0; b < NBEAT; b++) begin : g_beat
    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
      int p;
      always_comb begin
        p = fb * BUS_BYTES + b * BUS_BYTES + j;
        strb[b*BUS_BYTES + j] = wr && (p >= s) && (p <= l);
      end
    end
  end

endmodule

// File: rtl/axs_split.sv
`timescale 1ns/1ps
module axs_split #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int CW         = 6,
  parameter int LENW       = 8,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int NBEAT     = LINE_BYTES / BUS_BYTES,
  localparam int SW        = NBEAT * BUS_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic            req_wordmode,
  input  logic [CW-1:0]   req_count,
  output logic            ax_valid,
  input  logic            ax_ready,
  output logic            ax_write,
  output logic [AW-1:0]   ax_addr,
  output logic [1:0]      ax_burst,
  output logic [2:0]      ax_size,
  output logic [LENW-1:0] ax_len,
  output logic [SW-1:0]   ax_strb
);
  import axs_pkg::*;

  // internal events, visible to the checker
  logic            ev_accept;
  logic            ev_issue;
  logic            in_tail;
  logic            split;
  logic [AW-1:0]   lat_addr;
  logic            lat_write;
  logic            lat_wordmode;
  logic [CW-1:0]   lat_count;
  logic [OFFW:0]   head_n;
  logic [OFFW:0]   tail_n;
  logic [2:0]      nat_lg;

  logic [2:0]      p_sz   [2];
  logic [OFFW-1:0] p_aoff [2];
  logic [LENW-1:0] p_len  [2];
  logic [SW-1:0]   p_strb [2];

  logic [AW-OFFW-1:0] line_q;
  logic [AW-1:0]      head_addr;
  logic [AW-1:0]      tail_addr;

  axs_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_wordmode (req_wordmode),
    .req_count    (req_count),
    .ax_ready     (ax_ready),
    .split        (split),
    .ax_valid     (ax_valid),
    .in_tail      (in_tail),
    .ev_accept    (ev_accept),
    .ev_issue     (ev_issue),
    .lat_addr     (lat_addr),
    .lat_write    (lat_write),
    .lat_wordmode (lat_wordmode),
    .lat_count    (lat_count)
  );

  axs_plan #(.LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES), .CW(CW)) u_plan (
    .off      (lat_addr[OFFW-1:0]),
    .count    (lat_count),
    .wordmode (lat_wordmode),
    .split    (split),
    .head_n   (head_n),
    .tail_n   (tail_n),
    .nat_lg   (nat_lg)
  );

  // piece 0 = head (or whole access), piece 1 = tail on the next line
  for (genvar g = 0; g < 2; g++) begin : g_piece
    axs_piece #(.LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES), .LENW(LENW)) u_piece (
      .start_off (g == 0 ? lat_addr[OFFW-1:0] : '0),
      .nbytes    (g == 0 ? head_n : tail_n),
      .is_tail   (g != 0),
      .nat_lg    (nat_lg),
      .wr        (lat_write),
      .sz        (p_sz[g]),
      .aoff      (p_aoff[g]),
      .len       (p_len[g]),
      .strb      (p_strb[g])
    );
  end

  assign line_q    = lat_addr[AW-1:OFFW];
  assign head_addr = {line_q, p_aoff[0]};
  assign tail_addr = {line_q + 1'b1, p_aoff[1]};

  assign ax_write = lat_write;
  assign ax_burst = BURST_INCR;
  assign ax_addr  = in_tail ? tail_addr : head_addr;
  assign ax_size  = in_tail ? p_sz[1]   : p_sz[0];
  assign ax_len   = in_tail ? p_len[1]  : p_len[0];
  assign ax_strb  = in_tail ? p_strb[1] : p_strb[0];

endmodule

// File: rtl/axs_split_chk.sv
`timescale 1ns/1ps
module axs_split_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LENW       = 8,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int BOFF      = $clog2(BUS_BYTES),
  localparam int SW        = (LINE_BYTES / BUS_BYTES) * BUS_BYTES
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            ax_valid,
  input logic            ax_ready,
  input logic            ax_write,
  input logic [AW-1:0]   ax_addr,
  input logic [1:0]      ax_burst,
  input logic [2:0]      ax_size,
  input logic [LENW-1:0] ax_len,
  input logic [SW-1:0]   ax_strb,
  input logic            ev_accept,
  input logic            in_tail
);

  int            reach;
  logic [AW-1:0] size_mask;

  always_comb begin
    reach     = int'(ax_addr[OFFW-1:0]) + ((int'(ax_len) + 1) << int'(ax_size));
    size_mask = (AW'(1) << ax_size) - AW'(1);
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> ax_valid && !req_ready);

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && !ax_ready |=> ax_valid && $stable(ax_addr) && $stable(ax_size)
                              && $stable(ax_len) && $stable(ax_strb) && $stable(in_tail));

  // R3
  burst_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid |-> ax_burst == 2'b01);

  // R7
  read_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && !ax_write |-> ax_strb == '0);

  // R4
  multi_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && ax_len != '0 |-> ax_size == 3'(BOFF) && ax_addr[BOFF-1:0] == '0);

  // R2
  in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid |-> reach <= LINE_BYTES);

  // R6
  tail_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && in_tail |-> ax_addr[OFFW-1:0] == '0);

  // R5
  size_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid |-> (ax_addr & size_mask) == '0);

endmodule

bind axs_split axs_split_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES), .LENW(LENW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ax_valid  (ax_valid),
  .ax_ready  (ax_ready),
  .ax_write  (ax_write),
  .ax_addr   (ax_addr),
  .ax_burst  (ax_burst),
  .ax_size   (ax_size),
  .ax_len    (ax_len),
  .ax_strb   (ax_strb),
  .ev_accept (ev_accept),
  .in_tail   (in_tail)
);

// File: tb/axs_split_tb.sv
`timescale 1ns/1ps
module axs_split_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wordmode = 1'b0;
  logic [5:0]  req_count = '0;
  logic        ax_valid;
  logic        ax_ready = 1'b0;
  logic        ax_write;
  logic [31:0] ax_addr;
  logic [1:0]  ax_burst;
  logic [2:0]  ax_size;
  logic [7:0]  ax_len;
  logic [31:0] ax_strb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  axs_split u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wordmode(req_wordmode),
    .req_count(req_count), .ax_valid(ax_valid), .ax_ready(ax_ready),
    .ax_write(ax_write), .ax_addr(ax_addr), .ax_burst(ax_burst),
    .ax_size(ax_size), .ax_len(ax_len), .ax_strb(ax_strb)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        wm;
    logic [5:0]  cnt;
    logic [1:0]  ntx;
    logic [31:0] a0;
    logic [2:0]  s0;
    logic [7:0]  l0;
    logic [31:0] b0;
    logic [31:0] a1;
    logic [2:0]  s1;
    logic [7:0]  l1;
    logic [31:0] b1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h00001010, 1'b0, 1'b1, 6'd6,  2'd2, 32'h00001010, 3'd3, 8'd1, 32'h0,        32'h00001020, 3'd3, 8'd0, 32'h0},
    '{32'h0000101D, 1'b0, 1'b0, 6'd4,  2'd2, 32'h0000101C, 3'd2, 8'd0, 32'h0,        32'h00001020, 3'd2, 8'd0, 32'h0},
    '{32'h0000101F, 1'b0, 1'b0, 6'd4,  2'd2, 32'h0000101F, 3'd0, 8'd0, 32'h0,        32'h00001020, 3'd2, 8'd0, 32'h0},
    '{32'h0000101F, 1'b1, 1'b0, 6'd2,  2'd2, 32'h0000101F, 3'd0, 8'd0, 32'h00000080, 32'h00001020, 3'd1, 8'd0, 32'h00000001},
    '{32'h00002004, 1'b1, 1'b0, 6'd4,  2'd1, 32'h00002004, 3'd2, 8'd0, 32'h000000F0, 32'h0,        3'd0, 8'd0, 32'h0},
    '{32'h00003006, 1'b1, 1'b0, 6'd8,  2'd1, 32'h00003000, 3'd3, 8'd1, 32'h00003FC0, 32'h0,        3'd0, 8'd0, 32'h0},
    '{32'h00004000, 1'b1, 1'b0, 6'd32, 2'd1, 32'h00004000, 3'd3, 8'd3, 32'hFFFFFFFF, 32'h0,        3'd0, 8'd0, 32'h0},
    '{32'h0000501E, 1'b1, 1'b0, 6'd3,  2'd2, 32'h0000501E, 3'd1, 8'd0, 32'h000000C0, 32'h00005020, 3'd2, 8'd0, 32'h00000001},
    '{32'h00006003, 1'b1, 1'b0, 6'd1,  2'd1, 32'h00006003, 3'd0, 8'd0, 32'h00000008, 32'h0,        3'd0, 8'd0, 32'h0},
    '{32'h00007018, 1'b1, 1'b1, 6'd3,  2'd2, 32'h00007018, 3'd3, 8'd0, 32'h000000FF, 32'h00007020, 3'd3, 8'd0, 32'h0000000F},
    '{32'h00008005, 1'b0, 1'b0, 6'd2,  2'd1, 32'h00008004, 3'd2, 8'd0, 32'h0,        32'h0,        3'd0, 8'd0, 32'h0},
    '{32'hFFFFFFFC, 1'b0, 1'b0, 6'd8,  2'd2, 32'hFFFFFFFC, 3'd2, 8'd0, 32'h0,        32'h00000000, 3'd3, 8'd0, 32'h0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string size_req(input logic [7:0] len, input int t);
    if (len != 0) return "R4";
    else if (t == 1) return "R6";
    return "R5";
  endfunction

  // runs one request; checks each transaction; busy_poke offers a stray request while busy
  task automatic run_req(input vec_t v, input bit stall, input bit busy_poke);
    @(negedge clk);
    chk("R1", "req_ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = v.addr; req_write = v.wr;
    req_wordmode = v.wm; req_count = v.cnt;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < int'(v.ntx); t++) begin
      logic [31:0] ea, eb;
      logic [2:0]  es;
      logic [7:0]  el;
      ea = (t == 0) ? v.a0 : v.a1;
      es = (t == 0) ? v.s0 : v.s1;
      el = (t == 0) ? v.l0 : v.l1;
      eb = (t == 0) ? v.b0 : v.b1;
      if (stall) begin
        if (busy_poke) begin
          req_valid = 1'b1; req_addr = 32'h00009000; req_count = 6'd1;
        end
        chk("R8", "valid under stall", {31'b0, ax_valid}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "valid held", {31'b0, ax_valid}, 32'd1);
        chk("R8", "addr held", ax_addr, ea);
        req_valid = 1'b0;
      end
      chk("R1", "req_ready busy", {31'b0, req_ready}, 32'd0);
      chk("R2", "addr", ax_addr, ea);
      chk(size_req(el, t), "size", {29'b0, ax_size}, {29'b0, es});
      chk("R3", "len", {24'b0, ax_len}, {24'b0, el});
      chk("R3", "burst", {30'b0, ax_burst}, 32'd1);
      chk("R7", "strb", ax_strb, eb);
      chk("R2", "write", {31'b0, ax_write}, {31'b0, v.wr});
      ax_ready = 1'b1;
      @(negedge clk);
      ax_ready = 1'b0;
    end
    chk("R2", "no extra transaction", {31'b0, ax_valid}, 32'd0);
    chk("R1", "ready after drain", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    // R9: reset state
    chk("R9", "req_ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R9", "ax_valid in reset", {31'b0, ax_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R9", "ax_valid after reset", {31'b0, ax_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_req(VEC[i], (i % 2) == 1, 1'b0);

    // R1: stray request while busy on a split store leaves both pieces intact
    run_req(VEC[3], 1'b1, 1'b1);

    // R8: head then tail order under long stall on the wrapping load
    run_req(VEC[11], 1'b1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule